// File: doc/BRIEF.md
# SPI Flash Configuration Register Unit

This block is the command front end of a serial-flash slave. It watches the SPI pins (active-low select, clock, master-out data), assembles command bytes, and keeps the configuration state that the rest of the flash model relies on. That state is a 16-bit non-volatile configuration word, an 8-bit volatile configuration byte, an 8-bit enhanced volatile configuration byte, a write-enable latch, a reset-enable latch, a four-byte-address flag and an extended-address byte. Read commands return register contents on the master-in line. Write commands take data bytes after the opcode, but only while the write-enable latch is set. A two-frame software reset sequence rebuilds both volatile bytes from fields of the non-volatile word, and it may switch on four-byte addressing or load the extended address.

The SPI pins are oversampled by the system clock. Each pin passes through a synchronizer. Edges of the serial clock are detected in the system clock domain: data is captured on a rising serial-clock edge and the next output bit is presented on a falling edge (SPI mode 0, MSB first). The decoded fields are driven as plain mode outputs: write-enable state, four-byte mode, extended address, dummy-cycle count, the execute-in-place bit, and the dual and quad I/O bits.

The command state machine has five states. ST_IDLE waits for select; on frame start it goes to ST_OPCODE. ST_OPCODE takes the first byte. A write opcode with the latch set leads to ST_COLLECT. A read opcode leads to ST_READOUT. Every other byte leads to ST_IGNORE. ST_COLLECT and ST_READOUT move to ST_IGNORE after their last byte. Every state returns to ST_IDLE when select goes high.

Top module: `sfcfg_unit`

## Requirements
- R1: After system reset the non-volatile word equals parameter NV_INIT (default 16'h8FFF). The volatile, enhanced volatile, four-byte and extended-address state take the values that a software reset would derive from it: with the default these are 8'h83, 8'hDF, four-byte off and extended address 0. The write-enable latch is clear.
- R2: Transfers use SPI mode 0 with an active-low select and MSB-first bytes. While select is high, master-in is 0. Bytes clocked out beyond a read response, and during non-read commands, are 8'h00.
- R3: Opcode 8'h06 sets the write-enable latch and opcode 8'h04 clears it.
- R4: The write opcodes 8'hB1 (non-volatile), 8'h81 (volatile) and 8'h61 (enhanced volatile) are ignored while the latch is clear, and the target register keeps its value.
- R5: A non-volatile write takes two data bytes: the first goes to bits 7:0 and the second to bits 15:8. Read opcode 8'hB5 returns bits 7:0 and then bits 15:8.
- R6: The volatile and enhanced volatile writes each take one data byte. Read opcodes 8'h85 and 8'h65 return that byte.
- R7: A completed configuration write clears the write-enable latch.
- R8: Raising select before every data byte of a write has arrived leaves the target register unchanged and leaves the latch set.
- R9: Opcode 8'h99 resets only when the frame just before it carried opcode 8'h66. Any other opcode, including 8'h99 itself, clears the reset-enable latch.
- R10: A software reset clears the write-enable latch and the reset-enable latch.
- R11: On software reset the volatile byte becomes: bits 1:0 = 1, bit 2 = 0, bit 3 = 1 when non-volatile bits 11:9 differ from 3'b111, and bits 7:4 = non-volatile bits 15:12.
- R12: On software reset the enhanced volatile byte becomes: bits 4:0 = 1, bit 5 = 0, bit 6 = non-volatile bit 1, and bit 7 = non-volatile bit 3.
- R13: On software reset, four-byte mode turns on when non-volatile bit 0 is 0, and the extended address is loaded with 3 when non-volatile bit 1 is 0. Otherwise both keep their values.
- R14: The outputs give volatile bits 7:4 as the dummy-cycle count and volatile bit 3 as the execute-in-place bit. Enhanced volatile bits 6 and 7 give the dual and quad I/O bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low system reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Master-out data |
| spi_miso | output | 1 | Master-in data |
| wr_en_latch_o | output | 1 | Write-enable latch |
| four_byte_o | output | 1 | Four-byte address mode flag |
| ext_addr_o | output | EXT_W | Extended address byte |
| dummy_cycles_o | output | 4 | Dummy-cycle count field |
| xip_cfg_o | output | 1 | Execute-in-place bit of the volatile byte |
| dual_io_o | output | 1 | Dual I/O bit of the enhanced volatile byte |
| quad_io_o | output | 1 | Quad I/O bit of the enhanced volatile byte |

## Verification
The bench builds the unit with its defaults: NV_INIT 16'h8FFF, an 8-bit extended address and two synchronizer stages. The serial clock runs at one twelfth of the system clock. This lets the power-up derivation be compared against the reset formulas and leaves every edge-detect latency inside one serial half-period. The bench sweeps the volatile and enhanced volatile bytes over two dozen arithmetic patterns. It then steps the non-volatile word through sixteen computed values, each followed by a software reset. That walk covers both outcomes of the bit 11:9 comparison, of bits 0, 1 and 3, and of the sticky four-byte flag.

// File: rtl/sfcfg_pkg.sv
package sfcfg_pkg;
    localparam int BYTE_W = 8;
    localparam int NV_W   = 16;
    localparam int CFG_W  = 8;

    localparam logic [BYTE_W-1:0] OP_WREN    = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WRDI    = 8'h04;
    localparam logic [BYTE_W-1:0] OP_RD_NV   = 8'hB5;
    localparam logic [BYTE_W-1:0] OP_WR_NV   = 8'hB1;
    localparam logic [BYTE_W-1:0] OP_RD_VC   = 8'h85;
    localparam logic [BYTE_W-1:0] OP_WR_VC   = 8'h81;
    localparam logic [BYTE_W-1:0] OP_RD_EV   = 8'h65;
    localparam logic [BYTE_W-1:0] OP_WR_EV   = 8'h61;
    localparam logic [BYTE_W-1:0] OP_RST_EN  = 8'h66;
    localparam logic [BYTE_W-1:0] OP_RST_MEM = 8'h99;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_COLLECT,
        ST_READOUT,
        ST_IGNORE
    } state_e;

    typedef enum logic [1:0] {
        TGT_NV,
        TGT_VC,
        TGT_EV,
        TGT_NONE
    } target_e;

    function automatic logic is_write_op(input logic [BYTE_W-1:0] op);
        return (op == OP_WR_NV) || (op == OP_WR_VC) || (op == OP_WR_EV);
    endfunction

    function automatic logic is_read_op(input logic [BYTE_W-1:0] op);
        return (op == OP_RD_NV) || (op == OP_RD_VC) || (op == OP_RD_EV);
    endfunction

    // volatile byte rebuilt from the non-volatile word
    function automatic logic [CFG_W-1:0] vc_from_nv(input logic [NV_W-1:0] nv);
        logic [CFG_W-1:0] v;
        v      = '0;
        v[1:0] = 2'b11;
        v[3]   = (nv[11:9] != 3'b111);
        v[7:4] = nv[15:12];
        return v;
    endfunction

    // enhanced volatile byte rebuilt from the non-volatile word
    function automatic logic [CFG_W-1:0] ev_from_nv(input logic [NV_W-1:0] nv);
        logic [CFG_W-1:0] v;
        v      = '0;
        v[2:0] = 3'b111;
        v[3]   = 1'b1;
        v[4]   = 1'b1;
        v[6]   = nv[1];
        v[7]   = nv[3];
        return v;
    endfunction
endpackage

// File: rtl/sfcfg_sync.sv
module sfcfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain_q[s] <= d_i;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sfcfg_shifter.sv
module sfcfg_shifter
    import sfcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic [BYTE_W-1:0] tx_next,
    output logic              frame_act,
    output logic              frame_start,
    output logic              frame_end,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              spi_miso
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic cs_n_s, sck_s, mosi_s;
    logic cs_n_d, sck_d;
    logic sck_rise, sck_fall;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-2:0] rx_sr_q;
    logic [BYTE_W-1:0] tx_sr_q;

    sfcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d_i(spi_cs_n), .q_o(cs_n_s));
    sfcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .d_i(spi_sck), .q_o(sck_s));
    sfcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .d_i(spi_mosi), .q_o(mosi_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_d <= 1'b1;
            sck_d  <= 1'b0;
        end else begin
            cs_n_d <= cs_n_s;
            sck_d  <= sck_s;
        end
    end

    assign frame_act   = ~cs_n_s;
    assign frame_start = cs_n_d & ~cs_n_s;
    assign frame_end   = ~cs_n_d & cs_n_s;
    assign sck_rise    = frame_act & sck_s & ~sck_d;
    assign sck_fall    = frame_act & ~sck_s & sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sr_q   <= '0;
            tx_sr_q   <= '0;
        end else if (!frame_act) begin
            bit_cnt_q <= '0;
            tx_sr_q   <= '0;
        end else begin
            if (sck_rise) begin
                rx_sr_q   <= {rx_sr_q[BYTE_W-3:0], mosi_s};
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (sck_fall) begin
                tx_sr_q <= (bit_cnt_q == '0) ? tx_next : {tx_sr_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign byte_stb = sck_rise & (bit_cnt_q == CNT_W'(BYTE_W-1));
    assign rx_byte  = {rx_sr_q, mosi_s};
    assign spi_miso = tx_sr_q[BYTE_W-1];
endmodule

// File: rtl/sfcfg_ctrl.sv
module sfcfg_ctrl
    import sfcfg_pkg::*;
#(
    parameter logic [NV_W-1:0] NV_INIT = 16'h8FFF,
    parameter int              EXT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-1:0] tx_next,
    output logic [NV_W-1:0]   nv_q,
    output logic [CFG_W-1:0]  vc_q,
    output logic [CFG_W-1:0]  ev_q,
    output logic              wel_q,
    output logic              four_byte_q,
    output logic [EXT_W-1:0]  ext_q,
    output logic              soft_rst
);
    state_e            state_q, state_d;
    target_e           tgt_q;
    logic              cnt_q;
    logic              rsten_q;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] tx_q;
    logic              last_byte;

    assign last_byte = (tgt_q != TGT_NV) || cnt_q;
    assign soft_rst  = (state_q == ST_OPCODE) && byte_stb && (rx_byte == OP_RST_MEM) && rsten_q;
    assign tx_next   = tx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_start) state_d = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (frame_end) begin
                    state_d = ST_IDLE;
                end else if (byte_stb) begin
                    if (is_write_op(rx_byte) && wel_q) state_d = ST_COLLECT;
                    else if (is_read_op(rx_byte))     state_d = ST_READOUT;
                    else                               state_d = ST_IGNORE;
                end
            end
            ST_COLLECT, ST_READOUT: begin
                if (frame_end)                   state_d = ST_IDLE;
                else if (byte_stb && last_byte)  state_d = ST_IGNORE;
            end
            ST_IGNORE: begin
                if (frame_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nv_q        <= NV_INIT;
            vc_q        <= vc_from_nv(NV_INIT);
            ev_q        <= ev_from_nv(NV_INIT);
            wel_q       <= 1'b0;
            rsten_q     <= 1'b0;
            four_byte_q <= ~NV_INIT[0];
            ext_q       <= NV_INIT[1] ? '0 : EXT_W'(3);
            tgt_q       <= TGT_NONE;
            cnt_q       <= 1'b0;
            lo_q        <= '0;
            tx_q        <= '0;
        end else if (frame_start || frame_end) begin
            cnt_q <= 1'b0;
            tx_q  <= '0;
        end else if (byte_stb) begin
            unique case (state_q)
                ST_OPCODE: begin
                    cnt_q   <= 1'b0;
                    tx_q    <= '0;
                    tgt_q   <= TGT_NONE;
                    rsten_q <= (rx_byte == OP_RST_EN);
                    case (rx_byte)
                        OP_WREN:  wel_q <= 1'b1;
                        OP_WRDI:  wel_q <= 1'b0;
                        OP_RD_NV: begin tgt_q <= TGT_NV; tx_q <= nv_q[7:0]; end
                        OP_RD_VC: begin tgt_q <= TGT_VC; tx_q <= vc_q;      end
                        OP_RD_EV: begin tgt_q <= TGT_EV; tx_q <= ev_q;      end
                        OP_WR_NV: tgt_q <= TGT_NV;
                        OP_WR_VC: tgt_q <= TGT_VC;
                        OP_WR_EV: tgt_q <= TGT_EV;
                        OP_RST_MEM: begin
                            if (rsten_q) begin
                                wel_q <= 1'b0;
                                vc_q  <= vc_from_nv(nv_q);
                                ev_q  <= ev_from_nv(nv_q);
                                if (!nv_q[0]) four_byte_q <= 1'b1;
                                if (!nv_q[1]) ext_q       <= EXT_W'(3);
                            end
                        end
                        default: ;
                    endcase
                end
                ST_COLLECT: begin
                    if (!last_byte) begin
                        lo_q  <= rx_byte;
                        cnt_q <= 1'b1;
                    end else begin
                        wel_q <= 1'b0;
                        unique case (tgt_q)
                            TGT_NV:  nv_q <= {rx_byte, lo_q};
                            TGT_VC:  vc_q <= rx_byte;
                            TGT_EV:  ev_q <= rx_byte;
                            default: ;
                        endcase
                    end
                end
                ST_READOUT: begin
                    if (!last_byte) begin
                        tx_q  <= nv_q[15:8];
                        cnt_q <= 1'b1;
                    end else begin
                        tx_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sfcfg_unit.sv
module sfcfg_unit
    import sfcfg_pkg::*;
#(
    parameter logic [NV_W-1:0] NV_INIT     = 16'h8FFF,
    parameter int              EXT_W       = 8,
    parameter int              SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_cs_n,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic             wr_en_latch_o,
    output logic             four_byte_o,
    output logic [EXT_W-1:0] ext_addr_o,
    output logic [3:0]       dummy_cycles_o,
    output logic             xip_cfg_o,
    output logic             dual_io_o,
    output logic             quad_io_o
);
    logic              frame_act, frame_start, frame_end, byte_stb, soft_rst;
    logic [BYTE_W-1:0] rx_byte, tx_next;
    logic [NV_W-1:0]   nv_q;
    logic [CFG_W-1:0]  vc_q, ev_q;

    sfcfg_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .tx_next(tx_next),
        .frame_act(frame_act), .frame_start(frame_start), .frame_end(frame_end),
        .byte_stb(byte_stb), .rx_byte(rx_byte), .spi_miso(spi_miso));

    sfcfg_ctrl #(.NV_INIT(NV_INIT), .EXT_W(EXT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .frame_end(frame_end),
        .byte_stb(byte_stb), .rx_byte(rx_byte), .tx_next(tx_next),
        .nv_q(nv_q), .vc_q(vc_q), .ev_q(ev_q),
        .wel_q(wr_en_latch_o), .four_byte_q(four_byte_o), .ext_q(ext_addr_o),
        .soft_rst(soft_rst));

    assign dummy_cycles_o = vc_q[7:4];
    assign xip_cfg_o      = vc_q[3];
    assign dual_io_o      = ev_q[6];
    assign quad_io_o      = ev_q[7];
endmodule

// File: rtl/sfcfg_checker.sv
module sfcfg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_act,
    input logic        byte_stb,
    input logic        soft_rst,
    input logic        wel,
    input logic [15:0] nv,
    input logic [7:0]  vc,
    input logic [7:0]  ev,
    input logic        miso
);
    assert_miso_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |=> !miso);

    assert_nv_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(nv) |-> $past(wel));

    assert_vc_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vc) |-> ($past(wel) || $past(soft_rst)));

    assert_ev_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ev) |-> ($past(wel) || $past(soft_rst)));

    assert_wel_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(byte_stb));

    assert_cfg_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> ($stable(nv) && $stable(vc) && $stable(ev)));

    assert_soft_clears_wel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !wel);
endmodule

bind sfcfg_unit sfcfg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .byte_stb(byte_stb),
    .soft_rst(soft_rst), .wel(wr_en_latch_o), .nv(nv_q), .vc(vc_q), .ev(ev_q),
    .miso(spi_miso));

// File: tb/tb_sfcfg_unit.sv
`timescale 1ns/1ps
module tb_sfcfg_unit;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       wr_en_latch_o, four_byte_o, xip_cfg_o, dual_io_o, quad_io_o;
    logic [7:0] ext_addr_o;
    logic [3:0] dummy_cycles_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_nv;
    logic [7:0]  m_vc, m_ev, m_ext;
    logic        m_fb;

    always #2.5 clk = ~clk;

    sfcfg_unit dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .wr_en_latch_o(wr_en_latch_o),
        .four_byte_o(four_byte_o), .ext_addr_o(ext_addr_o),
        .dummy_cycles_o(dummy_cycles_o), .xip_cfg_o(xip_cfg_o),
        .dual_io_o(dual_io_o), .quad_io_o(quad_io_o));

    function automatic logic [7:0] exp_vc(input logic [15:0] nv);
        return 8'h03 + ((nv[11:9] != 3'b111) ? 8'h08 : 8'h00) + 8'(nv[15:12]) * 8'd16;
    endfunction

    function automatic logic [7:0] exp_ev(input logic [15:0] nv);
        return 8'h1F + (nv[1] ? 8'h40 : 8'h00) + (nv[3] ? 8'h80 : 8'h00);
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_on;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_off;
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (3*HALF) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] d;
        cs_on; xbyte(op, d); cs_off;
    endtask

    task automatic wr1(input logic [7:0] op, input logic [7:0] v);
        logic [7:0] d;
        cs_on; xbyte(op, d); xbyte(v, d); cs_off;
    endtask

    task automatic rd1(input logic [7:0] op, output logic [7:0] v);
        logic [7:0] d;
        cs_on; xbyte(op, d); xbyte(8'h00, v); cs_off;
    endtask

    task automatic wr_nv(input logic [15:0] v);
        logic [7:0] d;
        cs_on; xbyte(8'hB1, d); xbyte(v[7:0], d); xbyte(v[15:8], d); cs_off;
    endtask

    task automatic rd_nv(output logic [7:0] lo, output logic [7:0] hi);
        logic [7:0] d;
        cs_on; xbyte(8'hB5, d); xbyte(8'h00, lo); xbyte(8'h00, hi); cs_off;
    endtask

    task automatic check_regs(input string tag);
        logic [7:0] lo, hi, v;
        rd_nv(lo, hi);
        chk({tag, " R5 nv"}, {hi, lo}, m_nv);
        rd1(8'h85, v);
        chk({tag, " R6 vc"}, {8'h00, v}, {8'h00, m_vc});
        rd1(8'h65, v);
        chk({tag, " R6 ev"}, {8'h00, v}, {8'h00, m_ev});
    endtask

    task automatic check_flags(input string tag);
        chk({tag, " R13 four_byte"}, {15'd0, four_byte_o}, {15'd0, m_fb});
        chk({tag, " R13 ext_addr"}, {8'd0, ext_addr_o}, {8'd0, m_ext});
        chk({tag, " R14 dummy"}, {12'd0, dummy_cycles_o}, {12'd0, m_vc[7:4]});
        chk({tag, " R14 xip"}, {15'd0, xip_cfg_o}, {15'd0, m_vc[3]});
        chk({tag, " R14 dual"}, {15'd0, dual_io_o}, {15'd0, m_ev[6]});
        chk({tag, " R14 quad"}, {15'd0, quad_io_o}, {15'd0, m_ev[7]});
    endtask

    task automatic model_soft;
        m_vc = exp_vc(m_nv);
        m_ev = exp_ev(m_nv);
        if (!m_nv[0]) m_fb = 1'b1;
        if (!m_nv[1]) m_ext = 8'd3;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v, lo, hi;
        logic [15:0] nv;

        m_nv  = 16'h8FFF;
        m_vc  = exp_vc(m_nv);
        m_ev  = exp_ev(m_nv);
        m_fb  = ~m_nv[0];
        m_ext = m_nv[1] ? 8'd0 : 8'd3;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: power-up state
        chk("R1 wel", {15'd0, wr_en_latch_o}, 16'd0);
        chk("R1 vc expected 83", {8'd0, m_vc}, 16'h0083);
        chk("R1 ev expected DF", {8'd0, m_ev}, 16'h00DF);
        chk("R2 miso idle", {15'd0, spi_miso}, 16'd0);
        check_flags("R1");
        check_regs("R1");

        // R4: writes without the latch
        wr1(8'h81, 8'h55);
        wr1(8'h61, 8'h22);
        wr_nv(16'h1234);
        check_regs("R4 ignored");
        chk("R4 wel", {15'd0, wr_en_latch_o}, 16'd0);

        // R3: latch set / clear
        cmd(8'h06);
        chk("R3 set", {15'd0, wr_en_latch_o}, 16'd1);
        cmd(8'h04);
        chk("R3 clear", {15'd0, wr_en_latch_o}, 16'd0);

        // R2: response tail and idle line
        cs_on; xbyte(8'h65, v); xbyte(8'h00, v);
        chk("R2 first ev byte", {8'd0, v}, {8'd0, m_ev});
        xbyte(8'h00, v);
        chk("R2 tail zero", {8'd0, v}, 16'd0);
        cs_off;
        chk("R2 miso after frame", {15'd0, spi_miso}, 16'd0);

        // R6/R7/R14: sweep volatile bytes
        for (int i = 0; i < 24; i++) begin
            v = 8'(i * 37 + 5);
            cmd(8'h06);
            wr1(8'h81, v);
            m_vc = v;
            chk("R7 wel after vc write", {15'd0, wr_en_latch_o}, 16'd0);
            cmd(8'h06);
            wr1(8'h61, ~v);
            m_ev = ~v;
            rd1(8'h85, lo);
            chk("R6 vc sweep", {8'd0, lo}, {8'd0, m_vc});
            rd1(8'h65, lo);
            chk("R6 ev sweep", {8'd0, lo}, {8'd0, m_ev});
            check_flags("R14 sweep");
        end

        // R5: byte order
        cmd(8'h06);
        wr_nv(16'hA5C3);
        m_nv = 16'hA5C3;
        chk("R7 wel after nv write", {15'd0, wr_en_latch_o}, 16'd0);
        rd_nv(lo, hi);
        chk("R5 low byte first", {8'd0, lo}, 16'h00C3);
        chk("R5 high byte second", {8'd0, hi}, 16'h00A5);

        // R8: aborted writes
        cmd(8'h06);
        cs_on; xbyte(8'hB1, v); xbyte(8'h11, v); cs_off;
        chk("R8 wel kept", {15'd0, wr_en_latch_o}, 16'd1);
        cs_on; xbyte(8'h81, v); cs_off;
        chk("R8 wel kept vc", {15'd0, wr_en_latch_o}, 16'd1);
        check_regs("R8 aborted");
        cmd(8'h04);

        // R9: reset sequence rules
        cmd(8'h06); wr1(8'h81, 8'h5A); m_vc = 8'h5A;
        cmd(8'h99);
        rd1(8'h85, v);
        chk("R9 lone reset ignored", {8'd0, v}, 16'h005A);
        cmd(8'h66); rd1(8'h85, v); cmd(8'h99);
        rd1(8'h85, v);
        chk("R9 interrupted sequence ignored", {8'd0, v}, 16'h005A);
        cmd(8'h66); cmd(8'h66); cmd(8'h99);
        model_soft;
        check_regs("R9 repeated enable");

        // restore default word, reset, four-byte stays off
        cmd(8'h06); wr_nv(16'h8FFF); m_nv = 16'h8FFF;
        cmd(8'h66); cmd(8'h99); model_soft;
        check_flags("R13 default");

        // R10-R13: sweep non-volatile words
        for (int i = 0; i < 16; i++) begin
            nv = 16'((i * 16'h9E37) ^ (i << 3));
            if (i % 4 == 0) nv[11:9] = 3'b111;
            if (i % 8 == 1) nv[1] = 1'b1;
            cmd(8'h06);
            wr_nv(nv);
            m_nv = nv;
            cmd(8'h06);
            cmd(8'h66);
            cmd(8'h99);
            model_soft;
            chk("R10 wel cleared", {15'd0, wr_en_latch_o}, 16'd0);
            rd1(8'h85, v);
            chk("R11 vc rebuild", {8'd0, v}, {8'd0, m_vc});
            rd1(8'h65, v);
            chk("R12 ev rebuild", {8'd0, v}, {8'd0, m_ev});
            check_flags("R13 sweep");
            if (i < 3) begin
                cmd(8'h06); wr1(8'h81, 8'h00);
                cmd(8'h99);
                rd1(8'h85, v);
                chk("R10 reset-enable cleared", {8'd0, v}, 16'h0000);
                m_vc = 8'h00;
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule